// File: doc/BRIEF.md
# Atomic Access Control Checker

This block decides whether a conditional-store atomic operation may go ahead at an address that has already been translated. For every check it gets the result of the translation, the page's read and write rights, the page's cache class and a 6-bit atomic control word. It then either lets the operation pass or raises an exception with a cause code. The control word holds one 2-bit policy field for each cacheable class. A field of zero forbids atomics on pages of that class. Pages in isolate mode never allow atomics.

The verdict is registered. It appears on the cycle after the check strobe and lasts for that one cycle. A small two-state machine produces it. `ST_IDLE` means no exception is being reported. `ST_RAISE` means an exception is on the outputs. There are two transitions:
- `GO_RAISE`: a strobe whose check fails moves the machine to `ST_RAISE`.
- `GO_IDLE`: any cycle without a failing strobe moves it back to `ST_IDLE`.

A failing strobe while in `ST_RAISE` keeps the machine in `ST_RAISE`, so back-to-back faults give back-to-back reports. Address translation and the memory transaction itself are handled outside this block.

Top module: `atomic_ctl_checker`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `exc_valid` is 0 and `exc_cause` is 0.
- R2: A strobe with a nonzero `xlat_fault` raises an exception one cycle later, with `exc_cause` equal to that code. This takes priority over every other check.
- R3: A strobe with `xlat_fault` = 0, where the page is not both readable and writable, raises cause `STORE_PROHIB_CODE` (default 29). This takes priority over the control-field check. A load-prohibited cause is never produced.
- R4: The bypass class (`cache_class` = 0) is governed by `atom_ctl[1:0]`. If that field is 0, cause `LS_ERR_CODE` (default 3) is raised; otherwise the check passes.
- R5: The write-through class (`cache_class` = 1) is governed by `atom_ctl[3:2]`. A zero field raises `LS_ERR_CODE`.
- R6: The write-back class (`cache_class` = 2) is governed by `atom_ctl[5:4]`. A zero field raises `LS_ERR_CODE`.
- R7: The isolate class (`cache_class` = 3), with a data cache present and permissions good, always raises `LS_ERR_CODE`, whatever `atom_ctl` holds.
- R8: When `dcache_present` = 0, every class, isolate included, is treated as bypass and judged by `atom_ctl[1:0]` alone.
- R9: Classes 4 to 7, with a data cache present and permissions good, pass with no exception.
- R10: A verdict lasts exactly one cycle. A cycle with no strobe, or a passing strobe, gives `exc_valid` = 0 and `exc_cause` = 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_valid | input | 1 | Check strobe; the other inputs are sampled on this cycle |
| xlat_fault | input | 6 | Translation result code; 0 means the translation succeeded |
| perm_read | input | 1 | Page is readable |
| perm_write | input | 1 | Page is writable |
| cache_class | input | 3 | 0 bypass, 1 write-through, 2 write-back, 3 isolate, 4-7 other |
| dcache_present | input | 1 | A data cache is configured |
| atom_ctl | input | 6 | Atomic control word, three 2-bit policy fields |
| exc_valid | output | 1 | Exception raised for the check of the previous cycle |
| exc_cause | output | 6 | Cause code while `exc_valid` is high, 0 otherwise |

## Verification
Every result is due exactly one clock edge after the strobe that causes it, because there is one register between the inputs and the outputs. The bench drives stimulus on the falling edge. On the next falling edge it first compares both outputs against the model's prediction for the previous stimulus, and only then drives new stimulus. Idle cycles are compared as well, so a verdict that lasts too long or arrives late is caught.

// File: rtl/atomic_chk_pkg.sv
package atomic_chk_pkg;

    // Cache class encoding seen on cache_class
    localparam logic [2:0] CLS_BYPASS  = 3'd0;
    localparam logic [2:0] CLS_WTHRU   = 3'd1;
    localparam logic [2:0] CLS_WBACK   = 3'd2;
    localparam logic [2:0] CLS_ISOLATE = 3'd3;

    // Reporting state of the checker
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_RAISE = 1'b1
    } chk_state_e;

endpackage

// File: rtl/atomic_policy_sel.sv
// Works out the effective cache class and tests the policy field that governs it.
module atomic_policy_sel #(
    parameter int CTL_W   = 6,
    parameter int FIELD_W = 2,
    parameter int CLS_W   = 3
) (
    input  logic [CLS_W-1:0] cache_class,
    input  logic             dcache_present,
    input  logic [CTL_W-1:0] atom_ctl,
    output logic             policed,
    output logic             field_zero,
    output logic             isolate_hit
);
    import atomic_chk_pkg::*;

    localparam int NUM_FIELDS = CTL_W / FIELD_W;

    logic [CLS_W-1:0]      eff_class;
    logic [NUM_FIELDS-1:0] field_nz;
    logic [NUM_FIELDS-1:0] class_sel;

    // Without a data cache every page counts as bypass.
    always_comb begin
        eff_class = dcache_present ? cache_class : CLS_BYPASS;
    end

    for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
        assign field_nz[gi]  = |atom_ctl[gi*FIELD_W +: FIELD_W];
        assign class_sel[gi] = (eff_class == CLS_W'(gi));
    end

    always_comb begin
        policed     = |class_sel;
        field_zero  = |(class_sel & ~field_nz);
        isolate_hit = (eff_class == CLS_ISOLATE);
    end

endmodule

// File: rtl/atomic_fault_eval.sv
// Picks the single cause of a check, in priority order.
module atomic_fault_eval #(
    parameter int              CAUSE_W           = 6,
    parameter logic [CAUSE_W-1:0] STORE_PROHIB_CODE = 6'd29,
    parameter logic [CAUSE_W-1:0] LS_ERR_CODE       = 6'd3
) (
    input  logic [CAUSE_W-1:0] xlat_fault,
    input  logic               perm_read,
    input  logic               perm_write,
    input  logic               policed,
    input  logic               field_zero,
    input  logic               isolate_hit,
    output logic               fire,
    output logic [CAUSE_W-1:0] cause
);

    always_comb begin
        fire  = 1'b0;
        cause = '0;
        if (xlat_fault != '0) begin
            fire  = 1'b1;
            cause = xlat_fault;
        end else if (!(perm_read && perm_write)) begin
            fire  = 1'b1;
            cause = STORE_PROHIB_CODE;
        end else if (isolate_hit) begin
            fire  = 1'b1;
            cause = LS_ERR_CODE;
        end else if (policed && field_zero) begin
            fire  = 1'b1;
            cause = LS_ERR_CODE;
        end
    end

endmodule

// File: rtl/atomic_ctl_checker.sv
module atomic_ctl_checker #(
    parameter int                 CAUSE_W           = 6,
    parameter int                 CTL_W             = 6,
    parameter int                 FIELD_W           = 2,
    parameter int                 CLS_W             = 3,
    parameter logic [CAUSE_W-1:0] STORE_PROHIB_CODE = 6'd29,
    parameter logic [CAUSE_W-1:0] LS_ERR_CODE       = 6'd3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               chk_valid,
    input  logic [CAUSE_W-1:0] xlat_fault,
    input  logic               perm_read,
    input  logic               perm_write,
    input  logic [CLS_W-1:0]   cache_class,
    input  logic               dcache_present,
    input  logic [CTL_W-1:0]   atom_ctl,
    output logic               exc_valid,
    output logic [CAUSE_W-1:0] exc_cause
);
    import atomic_chk_pkg::*;

    logic               policed;
    logic               field_zero;
    logic               isolate_hit;
    logic               fire;
    logic [CAUSE_W-1:0] cause;

    chk_state_e         state_q;
    chk_state_e         state_d;
    logic [CAUSE_W-1:0] cause_q;

    atomic_policy_sel #(
        .CTL_W   (CTL_W),
        .FIELD_W (FIELD_W),
        .CLS_W   (CLS_W)
    ) u_sel (
        .cache_class    (cache_class),
        .dcache_present (dcache_present),
        .atom_ctl       (atom_ctl),
        .policed        (policed),
        .field_zero     (field_zero),
        .isolate_hit    (isolate_hit)
    );

    atomic_fault_eval #(
        .CAUSE_W           (CAUSE_W),
        .STORE_PROHIB_CODE (STORE_PROHIB_CODE),
        .LS_ERR_CODE       (LS_ERR_CODE)
    ) u_eval (
        .xlat_fault  (xlat_fault),
        .perm_read   (perm_read),
        .perm_write  (perm_write),
        .policed     (policed),
        .field_zero  (field_zero),
        .isolate_hit (isolate_hit),
        .fire        (fire),
        .cause       (cause)
    );

    // Next state: GO_RAISE on a failing strobe, GO_IDLE otherwise
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE:  state_d = (chk_valid && fire) ? ST_RAISE : ST_IDLE;
            ST_RAISE: state_d = (chk_valid && fire) ? ST_RAISE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n)                 cause_q <= '0;
        else if (chk_valid && fire) cause_q <= cause;
        else                        cause_q <= '0;
    end

    assign exc_valid = (state_q == ST_RAISE);
    assign exc_cause = cause_q;

endmodule

// File: rtl/atomic_ctl_checker_sva.sv
module atomic_ctl_checker_sva #(
    parameter int                 CAUSE_W           = 6,
    parameter int                 CTL_W             = 6,
    parameter int                 CLS_W             = 3,
    parameter logic [CAUSE_W-1:0] STORE_PROHIB_CODE = 6'd29,
    parameter logic [CAUSE_W-1:0] LS_ERR_CODE       = 6'd3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               chk_valid,
    input logic [CAUSE_W-1:0] xlat_fault,
    input logic               perm_read,
    input logic               perm_write,
    input logic [CLS_W-1:0]   cache_class,
    input logic               dcache_present,
    input logic [CTL_W-1:0]   atom_ctl,
    input logic               exc_valid,
    input logic [CAUSE_W-1:0] exc_cause
);

    logic perm_ok;
    assign perm_ok = (xlat_fault == '0) && perm_read && perm_write;

    p_xlat_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid && xlat_fault != '0 |=> exc_valid && exc_cause == $past(xlat_fault));

    p_store_prohib_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid && xlat_fault == '0 && !(perm_read && perm_write)
        |=> exc_valid && exc_cause == STORE_PROHIB_CODE);

    p_isolate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid && perm_ok && dcache_present && cache_class == 3'd3
        |=> exc_valid && exc_cause == LS_ERR_CODE);

    p_nodcache_r8: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid && perm_ok && !dcache_present && atom_ctl[1:0] != 2'b00 |=> !exc_valid);

    p_other_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid && perm_ok && dcache_present && cache_class[2] |=> !exc_valid);

    p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !exc_valid && exc_cause == '0);

    p_quiet_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid |-> exc_cause == '0);

endmodule

bind atomic_ctl_checker atomic_ctl_checker_sva #(
    .CAUSE_W           (CAUSE_W),
    .CTL_W             (CTL_W),
    .CLS_W             (CLS_W),
    .STORE_PROHIB_CODE (STORE_PROHIB_CODE),
    .LS_ERR_CODE       (LS_ERR_CODE)
) u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .chk_valid      (chk_valid),
    .xlat_fault     (xlat_fault),
    .perm_read      (perm_read),
    .perm_write     (perm_write),
    .cache_class    (cache_class),
    .dcache_present (dcache_present),
    .atom_ctl       (atom_ctl),
    .exc_valid      (exc_valid),
    .exc_cause      (exc_cause)
);

// File: tb/atomic_ctl_checker_test.sv
module atomic_ctl_checker_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chk_valid = 1'b0;
    logic [5:0] xlat_fault = '0;
    logic       perm_read = 1'b0;
    logic       perm_write = 1'b0;
    logic [2:0] cache_class = '0;
    logic       dcache_present = 1'b0;
    logic [5:0] atom_ctl = '0;
    logic       exc_valid;
    logic [5:0] exc_cause;

    int total = 0;
    int bad = 0;
    bit        exp_v = 1'b0;
    logic [5:0] exp_c = '0;
    string     exp_tag = "R1";

    always #5 clk = ~clk;

    atomic_ctl_checker uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .chk_valid      (chk_valid),
        .xlat_fault     (xlat_fault),
        .perm_read      (perm_read),
        .perm_write     (perm_write),
        .cache_class    (cache_class),
        .dcache_present (dcache_present),
        .atom_ctl       (atom_ctl),
        .exc_valid      (exc_valid),
        .exc_cause      (exc_cause)
    );

    task automatic compare();
        total++;
        if (exc_valid !== exp_v || exc_cause !== exp_c) begin
            bad++;
            $display("FAIL %s: valid=%0b cause=%0d expected valid=%0b cause=%0d",
                     exp_tag, exc_valid, exc_cause, exp_v, exp_c);
        end
    endtask

    // Behavioural reference: verdict for one stimulus, due on the next cycle
    task automatic predict(input bit c, input logic [5:0] code, input bit rd, input bit wr,
                           input logic [2:0] cls, input bit dc, input logic [5:0] ctl);
        int fidx;
        exp_v = 1'b0;
        exp_c = '0;
        if (!c) begin
            exp_tag = "R10";
            return;
        end
        if (code != 0) begin
            exp_v = 1'b1; exp_c = code; exp_tag = "R2"; return;
        end
        if (!(rd && wr)) begin
            exp_v = 1'b1; exp_c = 6'd29; exp_tag = "R3"; return;
        end
        fidx = dc ? int'(cls) : 0;
        if (!dc) exp_tag = "R8";
        else if (fidx == 3) begin
            exp_v = 1'b1; exp_c = 6'd3; exp_tag = "R7"; return;
        end else if (fidx >= 4) begin
            exp_tag = "R9"; return;
        end else if (fidx == 0) exp_tag = "R4";
        else if (fidx == 1) exp_tag = "R5";
        else exp_tag = "R6";
        if (((ctl >> (2 * fidx)) & 6'h3) == 0) begin
            exp_v = 1'b1; exp_c = 6'd3;
        end
    endtask

    task automatic step(input bit c, input logic [5:0] code, input bit rd, input bit wr,
                        input logic [2:0] cls, input bit dc, input logic [5:0] ctl);
        @(negedge clk);
        compare();
        chk_valid = c; xlat_fault = code; perm_read = rd; perm_write = wr;
        cache_class = cls; dcache_present = dc; atom_ctl = ctl;
        predict(c, code, rd, wr, cls, dc, ctl);
    endtask

    initial begin
        // R1: outputs quiet during reset
        repeat (2) @(negedge clk);
        compare();
        rst_n = 1'b1;
        // R1: and on the first cycle after reset
        step(0, 0, 1, 1, 0, 1, 6'h3f);
        // R2: translation fault wins even over a bad permission / isolate page
        step(1, 6'd24, 0, 0, 3'd3, 1, 6'h00);
        step(1, 6'd16, 1, 1, 3'd0, 1, 6'h3f);
        // R3: permission faults
        step(1, 0, 1, 0, 3'd0, 1, 6'h3f);
        step(1, 0, 0, 1, 3'd2, 1, 6'h00);
        step(1, 0, 0, 0, 3'd5, 0, 6'h3f);
        // R4: bypass field bits 1:0
        step(1, 0, 1, 1, 3'd0, 1, 6'h3c);
        step(1, 0, 1, 1, 3'd0, 1, 6'h02);
        // R5: write-through field bits 3:2
        step(1, 0, 1, 1, 3'd1, 1, 6'h33);
        step(1, 0, 1, 1, 3'd1, 1, 6'h04);
        // R6: write-back field bits 5:4
        step(1, 0, 1, 1, 3'd2, 1, 6'h0f);
        step(1, 0, 1, 1, 3'd2, 1, 6'h20);
        // R7: isolate always faults
        step(1, 0, 1, 1, 3'd3, 1, 6'h3f);
        // R8: no data cache, everything judged by bits 1:0
        step(1, 0, 1, 1, 3'd3, 0, 6'h01);
        step(1, 0, 1, 1, 3'd2, 0, 6'h30);
        step(1, 0, 1, 1, 3'd6, 0, 6'h3c);
        // R9: other classes pass
        step(1, 0, 1, 1, 3'd4, 1, 6'h00);
        step(1, 0, 1, 1, 3'd7, 1, 6'h00);
        // R10: verdict lasts one cycle, idle inputs ignored
        step(1, 0, 1, 1, 3'd1, 1, 6'h00);
        step(0, 6'd9, 0, 0, 3'd3, 1, 6'h00);
        step(0, 0, 1, 1, 3'd0, 1, 6'h00);
        for (int i = 0; i < 24; i++) begin
            step(1, (i % 5 == 0) ? 6'(i) : 6'd0, (i % 7) != 3, (i % 4) != 1,
                 3'(i), (i % 3) != 0, 6'(i * 11));
        end
        step(0, 0, 0, 0, 3'd0, 0, 6'h00);
        step(0, 0, 0, 0, 3'd0, 0, 6'h00);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        bad++;
        total++;
        $display("FAIL watchdog: valid=%0b cause=%0d expected run to end", exc_valid, exc_cause);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule